// File: doc/BRIEF.md
# Tracking Angle Output Latch Controller

This block sits behind the up/down position counter of a tracking angle converter. The counter runs freely and reports every one-LSB move with a step strobe. The block decides when the counter word is copied into an output holding register. Around each copy it drives a timed active-high BUSY pulse. The register changes a few cycles after BUSY rises and is settled once BUSY falls, so the falling edge marks valid data.

An active-low hold input freezes the holding register while the counter keeps tracking. When the hold is released, the block issues one refresh pulse. The held word goes out on two byte lanes, each with its own active-low enable. The upper lane always carries 8 bits. The lower lane carries 6 bits for 14-bit resolution or 4 bits for 12-bit resolution. Each lane is modelled as a data vector plus an output-enable instead of a true three-state pin.

All timing is counted in cycles of one clock. The defaults assume 50 MHz: BUSY lasts 20 cycles (400 ns), the register updates 3 cycles after BUSY rises, and the hold settle window is 32 cycles (640 ns).

Top module: `angle_latch_ctrl`

## Requirements
- R1: A step strobe seen while `hold_n` is high starts a BUSY pulse, and after BUSY falls the output word equals the counter word presented with that step.
- R2: BUSY stays high for exactly BUSY_CYC cycles (default 20) and is low for at least one cycle between two pulses.
- R3: The held word changes only while BUSY is high, exactly LEAD_CYC cycles (default 3) after the first cycle in which BUSY is high.
- R4: Steps that arrive before the update point of a running pulse merge into that pulse. Steps that arrive after the update point produce exactly one follow-on pulse. In both cases the held word ends up equal to the latest counter word.
- R5: While `hold_n` is low, no new BUSY pulse starts and the held word does not change, whatever steps arrive.
- R6: A rising edge of `hold_n` starts exactly one BUSY pulse, which captures the counter word current at that time.
- R7: A pulse already running when `hold_n` falls completes its update, and the held word is stable from BUSY_CYC cycles after the fall (within the 640 ns settle window).
- R8: With `hi_en_n` low, `hi_oe_o` is 1 and `hi_data_o` carries the upper 8 bits of the held word. With `hi_en_n` high, `hi_oe_o` is 0 and `hi_data_o` is 0. The lower lane (`lo_en_n`, `lo_oe_o`, `lo_data_o`, RES_BITS-8 bits) behaves the same way.
- R9: The enables have no effect on BUSY or on updating the held word.
- R10: The word is natural binary. Word bit RES_BITS-1 (weight 180 degrees) appears on `hi_data_o[7]`, and word bit 0 appears on `lo_data_o[0]`.
- R11: After reset, BUSY is low and the held word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_word_i | input | RES_BITS | Current position counter word |
| step_i | input | 1 | One-cycle strobe: the counter moved by one LSB |
| hold_n | input | 1 | Active-low hold of the output register |
| hi_en_n | input | 1 | Active-low enable of the upper lane |
| lo_en_n | input | 1 | Active-low enable of the lower lane |
| busy_o | output | 1 | High while the output register is being refreshed |
| hi_data_o | output | 8 | Upper lane data, zero when disabled |
| hi_oe_o | output | 1 | Upper lane drive enable |
| lo_data_o | output | RES_BITS-8 | Lower lane data, zero when disabled |
| lo_oe_o | output | 1 | Lower lane drive enable |

## Verification
The bench builds two copies side by side. One uses RES_BITS=14 and the other RES_BITS=12, and both share BUSY_CYC=20 and LEAD_CYC=3. Driving both from the same stimulus exercises the 6-bit and the 4-bit lower-lane split and checks where the MSB lands in each. The short pulse and lead settings make the merge window and the follow-on window only a few cycles wide. This lets directed steps land precisely before or after the update point, and lets a hold fall inside a running pulse.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;

   localparam int HI_LANE_W = 8;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_t;

endpackage

// File: rtl/angle_busy_seq.sv
module angle_busy_seq
   import angle_latch_pkg::*;
#(
   parameter int BUSY_CYC = 20,
   parameter int LEAD_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   input  logic hold_n,
   output logic busy_o,
   output logic load_o
);

   localparam int CW = $clog2(BUSY_CYC + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(BUSY_CYC - 1);
   localparam logic [CW-1:0] LOAD_CNT = CW'(LEAD_CYC - 1);

   seq_state_t     state_q;
   logic [CW-1:0]  cnt_q;
   logic           pend_q;
   logic           done_q;
   logic           hold_q;
   logic           release_w;
   logic           want_w;
   logic           start_w;
   logic           late_w;

   assign release_w = hold_n & ~hold_q;
   assign want_w    = (step_i & hold_n) | release_w;
   assign start_w   = (state_q == SEQ_IDLE) & (want_w | (pend_q & hold_n));
   assign load_o    = (state_q == SEQ_BUSY) & (cnt_q == LOAD_CNT);
   assign late_w    = (state_q == SEQ_BUSY) & done_q & want_w;
   assign busy_o    = (state_q == SEQ_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         hold_q  <= 1'b1;
      end else begin
         hold_q <= hold_n;
         case (state_q)
            SEQ_IDLE: begin
               if (start_w) begin
                  state_q <= SEQ_BUSY;
                  cnt_q   <= '0;
                  done_q  <= 1'b0;
               end
            end
            default: begin
               cnt_q <= cnt_q + 1'b1;
               if (load_o) begin
                  done_q <= 1'b1;
               end
               if (cnt_q == LAST_CNT) begin
                  state_q <= SEQ_IDLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (load_o) begin
         pend_q <= 1'b0;
      end else if (late_w) begin
         pend_q <= 1'b1;
      end
   end

endmodule

// File: rtl/angle_word_latch.sv
module angle_word_latch #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] word_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
      end else if (load_i) begin
         word_o <= word_i;
      end
   end

endmodule

// File: rtl/angle_lane_drive.sv
module angle_lane_drive #(
   parameter int LW = 8
) (
   input  logic          en_n,
   input  logic [LW-1:0] data_i,
   output logic [LW-1:0] data_o,
   output logic          oe_o
);

   assign oe_o = ~en_n;

   for (genvar b = 0; b < LW; b++) begin : g_bit
      assign data_o[b] = data_i[b] & ~en_n;
   end

endmodule

// File: rtl/angle_latch_ctrl.sv
module angle_latch_ctrl
   import angle_latch_pkg::*;
#(
   parameter int RES_BITS   = 14,
   parameter int BUSY_CYC   = 20,
   parameter int LEAD_CYC   = 3,
   parameter int SETTLE_CYC = 32,
   localparam int LO_W      = RES_BITS - HI_LANE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RES_BITS-1:0]  cnt_word_i,
   input  logic                 step_i,
   input  logic                 hold_n,
   input  logic                 hi_en_n,
   input  logic                 lo_en_n,
   output logic                 busy_o,
   output logic [HI_LANE_W-1:0] hi_data_o,
   output logic                 hi_oe_o,
   output logic [LO_W-1:0]      lo_data_o,
   output logic                 lo_oe_o
);

   if (!(RES_BITS == 12 || RES_BITS == 14)) begin : g_bad_res
      $error("angle_latch_ctrl: RES_BITS must be 12 or 14");
   end
   if (LEAD_CYC < 1 || LEAD_CYC >= BUSY_CYC) begin : g_bad_lead
      $error("angle_latch_ctrl: LEAD_CYC must lie in 1..BUSY_CYC-1");
   end
   if (BUSY_CYC > SETTLE_CYC) begin : g_bad_settle
      $error("angle_latch_ctrl: BUSY_CYC must fit in SETTLE_CYC");
   end

   logic                load_w;
   logic [RES_BITS-1:0] latch_q;

   angle_busy_seq #(
      .BUSY_CYC (BUSY_CYC),
      .LEAD_CYC (LEAD_CYC)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_i),
      .hold_n (hold_n),
      .busy_o (busy_o),
      .load_o (load_w)
   );

   angle_word_latch #(
      .W (RES_BITS)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_w),
      .word_i (cnt_word_i),
      .word_o (latch_q)
   );

   angle_lane_drive #(
      .LW (HI_LANE_W)
   ) u_hi_lane (
      .en_n   (hi_en_n),
      .data_i (latch_q[RES_BITS-1 -: HI_LANE_W]),
      .data_o (hi_data_o),
      .oe_o   (hi_oe_o)
   );

   angle_lane_drive #(
      .LW (LO_W)
   ) u_lo_lane (
      .en_n   (lo_en_n),
      .data_i (latch_q[LO_W-1:0]),
      .data_o (lo_data_o),
      .oe_o   (lo_oe_o)
   );

endmodule

// File: rtl/angle_latch_chk.sv
module angle_latch_chk #(
   parameter int W        = 14,
   parameter int BUSY_CYC = 20
) (
   input logic         clk,
   input logic         rst_n,
   input logic         busy_i,
   input logic         hold_n,
   input logic [W-1:0] word_i
);

   localparam int CW = $clog2(BUSY_CYC + 2) + 1;
   localparam logic [CW-1:0] CAP = CW'(BUSY_CYC + 1);

   logic [CW-1:0] run_q;
   logic [CW-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         low_q <= '0;
      end else begin
         run_q <= busy_i ? ((run_q == CAP) ? CAP : run_q + 1'b1) : '0;
         low_q <= hold_n ? '0 : ((low_q == CAP) ? CAP : low_q + 1'b1);
      end
   end

   AST_BUSY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (run_q < CW'(BUSY_CYC))); // R2
   AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |-> (run_q == CW'(BUSY_CYC))); // R2
   AST_UPDATE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_i) |-> busy_i); // R3
   AST_NO_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_i) |-> $past(hold_n)); // R5
   AST_HOLD_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_n && low_q > CW'(BUSY_CYC)) |-> $stable(word_i)); // R7

endmodule

bind angle_latch_ctrl angle_latch_chk #(
   .W        (RES_BITS),
   .BUSY_CYC (BUSY_CYC)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy_i (busy_o),
   .hold_n (hold_n),
   .word_i (latch_q)
);

// File: tb/angle_latch_ctrl_bench.sv
module angle_latch_ctrl_bench;

   localparam int CLK_PERIOD = 20;
   localparam int BUSY = 20;
   localparam int LEAD = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] word = '0;
   logic        step = 1'b0;
   logic        hold_n = 1'b1;
   logic        hi_en_n = 1'b0;
   logic        lo_en_n = 1'b0;

   logic        b14, ho14, lo14, b12, ho12, lo12;
   logic [7:0]  hd14, hd12;
   logic [5:0]  ld14;
   logic [3:0]  ld12;

   int tests = 0;
   int fails = 0;
   int pulses = 0;
   logic b_q = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   angle_latch_ctrl #(.RES_BITS(14), .BUSY_CYC(BUSY), .LEAD_CYC(LEAD)) u_angle_latch_ctrl (
      .clk(clk), .rst_n(rst_n), .cnt_word_i(word), .step_i(step), .hold_n(hold_n),
      .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .busy_o(b14), .hi_data_o(hd14),
      .hi_oe_o(ho14), .lo_data_o(ld14), .lo_oe_o(lo14));

   angle_latch_ctrl #(.RES_BITS(12), .BUSY_CYC(BUSY), .LEAD_CYC(LEAD)) u_angle_latch_ctrl_r12 (
      .clk(clk), .rst_n(rst_n), .cnt_word_i(word[11:0]), .step_i(step), .hold_n(hold_n),
      .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .busy_o(b12), .hi_data_o(hd12),
      .hi_oe_o(ho12), .lo_data_o(ld12), .lo_oe_o(lo12));

   always @(posedge clk) begin
      b_q <= b14;
      if (b14 && !b_q) pulses <= pulses + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [13:0] out14();
      return {hd14, ld14};
   endfunction

   function automatic logic [11:0] out12();
      return {hd12, ld12};
   endfunction

   task automatic step_to(input logic [13:0] w);
      @(negedge clk);
      word = w;
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
   endtask

   task automatic settle();
      repeat (BUSY + 8) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(b14 == 1'b0, "R11", "busy after reset", int'(b14), 0);
      chk(out14() == 14'h0, "R11", "word after reset", int'(out14()), 0);
   endtask

   task automatic t_single();
      int width = 0;
      int lead = -1;
      logic [13:0] prev;
      prev = out14();
      step_to(14'h1234);
      for (int k = 0; k < 60 && !b14; k++) @(negedge clk);
      while (b14 && width < 200) begin
         if (lead < 0 && out14() != prev) lead = width;
         @(negedge clk);
         width++;
      end
      chk(width == BUSY, "R2", "busy width", width, BUSY);
      chk(lead == LEAD, "R3", "update lead", lead, LEAD);
      chk(out14() == 14'h1234, "R1", "word after busy", int'(out14()), 'h1234);
      chk(out12() == 12'h234, "R1", "12-bit word", int'(out12()), 'h234);
      settle();
   endtask

   task automatic t_merge();
      int p0;
      p0 = pulses;
      step_to(14'h0111);
      word = 14'h0222;
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      settle();
      chk(pulses - p0 == 1, "R4", "merged pulse count", pulses - p0, 1);
      chk(out14() == 14'h0222, "R4", "merged word", int'(out14()), 'h0222);
   endtask

   task automatic t_follow();
      int p0;
      p0 = pulses;
      step_to(14'h0A0A);
      repeat (10) @(negedge clk);
      word = 14'h0B0B;
      step = 1'b1;
      @(negedge clk);
      word = 14'h0C0C;
      @(negedge clk);
      step = 1'b0;
      repeat (2 * BUSY + 10) @(negedge clk);
      chk(pulses - p0 == 2, "R4", "follow-on pulse count", pulses - p0, 2);
      chk(out14() == 14'h0C0C, "R4", "follow-on word", int'(out14()), 'h0C0C);
      chk(b14 == 1'b0, "R2", "busy idle after follow-on", int'(b14), 0);
   endtask

   task automatic t_hold();
      int p0;
      p0 = pulses;
      @(negedge clk);
      hold_n = 1'b0;
      step_to(14'h1111);
      step_to(14'h2222);
      repeat (30) @(negedge clk);
      chk(pulses == p0, "R5", "no pulse while held", pulses - p0, 0);
      chk(out14() == 14'h0C0C, "R5", "word frozen", int'(out14()), 'h0C0C);
      hold_n = 1'b1;
      settle();
      chk(pulses - p0 == 1, "R6", "release pulse count", pulses - p0, 1);
      chk(out14() == 14'h2222, "R6", "release word", int'(out14()), 'h2222);
   endtask

   task automatic t_hold_mid();
      logic [13:0] d1;
      step_to(14'h0333);
      @(negedge clk);
      hold_n = 1'b0;
      repeat (BUSY + 2) @(negedge clk);
      d1 = out14();
      step_to(14'h0444);
      repeat (10) @(negedge clk);
      chk(d1 == 14'h0333, "R7", "running pulse completes", int'(d1), 'h0333);
      chk(out14() == 14'h0333, "R7", "word stable after window", int'(out14()), 'h0333);
      hold_n = 1'b1;
      settle();
      chk(out14() == 14'h0444, "R6", "word after mid release", int'(out14()), 'h0444);
   endtask

   task automatic t_enables();
      int p0;
      @(negedge clk);
      hi_en_n = 1'b1;
      @(negedge clk);
      chk(ho14 == 1'b0 && hd14 == 8'h0, "R8", "upper lane off", int'({ho14, hd14}), 0);
      chk(lo14 == 1'b1 && ld14 == 6'h04, "R8", "lower lane on", int'({lo14, ld14}), 'h44);
      lo_en_n = 1'b1;
      p0 = pulses;
      step_to(14'h2A55);
      settle();
      chk(lo12 == 1'b0 && ld12 == 4'h0, "R8", "12-bit lower lane off", int'({lo12, ld12}), 0);
      chk(pulses - p0 == 1, "R9", "pulse with lanes off", pulses - p0, 1);
      hi_en_n = 1'b0;
      lo_en_n = 1'b0;
      @(negedge clk);
      chk(ho14 && lo14 && out14() == 14'h2A55, "R9", "word updated with lanes off",
          int'(out14()), 'h2A55);
   endtask

   task automatic t_order();
      step_to(14'h2000);
      settle();
      chk(hd14 == 8'h80 && ld14 == 6'h0, "R10", "14-bit MSB position",
          int'({hd14, ld14}), 'h2000);
      step_to(14'h0800);
      settle();
      chk(hd12 == 8'h80 && ld12 == 4'h0, "R10", "12-bit MSB position",
          int'({hd12, ld12}), 'h800);
      step_to(14'h0001);
      settle();
      chk(ld14[0] && ld12[0] && hd14 == 8'h0, "R10", "LSB position",
          int'({ld14[0], ld12[0]}), 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_single();
      t_merge();
      t_follow();
      t_hold();
      t_hold_mid();
      t_enables();
      t_order();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule